// File: doc/BRIEF.md
# Hardware Descriptor Queue Manager

This block holds a bank of word FIFOs through which a host processor and packet engines hand 32-bit descriptor pointers to each other. Each word is treated as opaque: the upper bits normally carry a 32-byte-aligned descriptor address, and the low five bits carry tag fields such as an engine number, a priority or a port number. The block stores and returns all 32 bits unchanged. Every queue has its own length, set when software allocates it. Software puts a word by writing the queue's data address. It gets the head word by reading that same address. A get from an empty queue returns zero, which software reads as "nothing there". The get does not stall.

Status is kept per queue. An empty vector shows which queues hold nothing. A sticky overflow vector records each put that arrived while the queue was full; that word is dropped. Each queue can select "not empty" as its interrupt source and can be masked or unmasked on its own. A pending vector shows which queues are currently raising the single interrupt output. The words themselves sit in one shared RAM, divided into one region of maximum depth per queue.

Access goes through a small request/response controller with three states. In `S_IDLE` it accepts a request. A read of a data address takes the transition IDLE→POP_RESP to `S_POP_RESP`, which returns the popped word. A read of any other address takes IDLE→REG_RESP to `S_REG_RESP`, which returns the captured register value. Both response states take the transition RESP→IDLE back to `S_IDLE` after one cycle. A write completes in `S_IDLE` and leaves the state unchanged.

Top module: `hwq_manager`

## Requirements
- R1: A write to address q (0..31) puts bus_wdata at the tail of queue q. A read of address q returns the head word of queue q and removes it. All 32 bits, including the five low tag bits, come back unchanged and in first-in first-out order. The read data appears with bus_rvalid high in the cycle after the request, and bus_ready is low in that cycle.
- R2: A read of address q while queue q is empty returns 0 and leaves the queue's contents and occupancy unchanged.
- R3: A write to address 0x20+q sets the length of queue q to bus_wdata[6:0]. A value of 0, or a value above the maximum depth (64), selects 64. Reading 0x20+q returns the length in effect. After reset every length is 64. The write also empties queue q and clears its overflow bit.
- R4: A put to a full queue drops the word, leaves the stored words and the order unchanged, and sets bit q of the overflow register at 0x41.
- R5: Writing a 1 to bit q of 0x41 clears overflow bit q. Writing a 0 to a bit leaves it unchanged.
- R6: Bit q of the empty register at 0x40 is 1 exactly when queue q holds no word.
- R7: Bit q of the pending register at 0x44 is (source select bit q at 0x42) AND (enable bit q at 0x43) AND (queue q not empty). The irq output is the OR of the pending bits. A change to a put, get or mask register shows on irq in the cycle after the write.
- R8: Each queue wraps its pointers at its configured length, so the first-in first-out order holds across the wrap.
- R9: After reset every queue is empty and the overflow, source select, enable and pending registers read 0, with irq low.
- R10: Addresses 0x60 to 0x7F read as 0, and writes to them change no queue or register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, taken when bus_ready is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address: [6:5] region, [4:0] queue or register index |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | High when a request can be accepted |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | OR of the enabled not-empty conditions |

## Verification
The hardest situation to reach from the ports is a put to a full queue that has already wrapped its pointers, followed by draining it. This is the case where a dropped word could overwrite the head, or where a wrong pointer could reorder the contents. The random stimulus reaches it often. It sends most operations to four queues, reallocates them with lengths from 1 to 9, and mixes puts and gets, so a queue fills, wraps and overflows many times. Directed cases add a completely filled 64-entry queue, a length-3 wrap, reallocation of a non-empty queue, and masking of a pending interrupt while the queue still holds data.

// File: rtl/qm_pkg.sv
package qm_pkg;

    // Upper two address bits pick the region.
    typedef enum logic [1:0] {
        RG_DATA   = 2'd0,
        RG_CFG    = 2'd1,
        RG_GLOBAL = 2'd2,
        RG_NONE   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_POP_RESP = 2'd1,
        S_REG_RESP = 2'd2
    } bus_state_e;

    // Register indexes inside the global region.
    localparam int unsigned G_EMPTY = 0;
    localparam int unsigned G_OVF   = 1;
    localparam int unsigned G_SRC   = 2;
    localparam int unsigned G_EN    = 3;
    localparam int unsigned G_PEND  = 4;

endpackage

// File: rtl/qm_qctrl.sv
// Pointer, occupancy, length and overflow tracking for one queue.
module qm_qctrl #(
    parameter int MAX_DEPTH = 64,
    parameter int PW        = 6,
    parameter int CW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          put_i,
    input  logic          get_i,
    input  logic          cfg_we_i,
    input  logic [CW-1:0] cfg_len_i,
    input  logic          ovf_clr_i,
    output logic [PW-1:0] rd_ptr_o,
    output logic [PW-1:0] wr_ptr_o,
    output logic [CW-1:0] len_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          ovf_o
);
    localparam logic [CW-1:0] MAXL = CW'(MAX_DEPTH);

    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, len, len_eff;
    logic          ovf, do_put, do_get;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic [CW-1:0] l);
        return ({1'b0, p} == (l - 1'b1)) ? '0 : p + 1'b1;
    endfunction

    assign empty_o  = (cnt == '0);
    assign full_o   = (cnt == len);
    assign do_put   = put_i && !full_o;
    assign do_get   = get_i && !empty_o;
    assign len_eff  = (cfg_len_i == '0 || cfg_len_i > MAXL) ? MAXL : cfg_len_i;
    assign rd_ptr_o = rd_ptr;
    assign wr_ptr_o = wr_ptr;
    assign len_o    = len;
    assign ovf_o    = ovf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            len    <= MAXL;
            ovf    <= 1'b0;
        end else if (cfg_we_i) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            len    <= len_eff;
            ovf    <= 1'b0;
        end else begin
            if (do_put) wr_ptr <= bump(wr_ptr, len);
            if (do_get) rd_ptr <= bump(rd_ptr, len);
            cnt <= cnt + CW'(do_put) - CW'(do_get);
            if (put_i && full_o) ovf <= 1'b1;
            else if (ovf_clr_i)  ovf <= 1'b0;
        end
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= len) && (len != '0));

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (put_i && full_o && !cfg_we_i) |=> (cnt == $past(cnt) && wr_ptr == $past(wr_ptr)));

    p_ovf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(put_i && full_o));

    p_empty_get_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (get_i && empty_o && !cfg_we_i) |=> (rd_ptr == $past(rd_ptr) && cnt == $past(cnt)));

endmodule

// File: rtl/qm_store.sv
// Shared word storage: one write port, one registered read port.
module qm_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 2048,
    parameter int MW     = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [MW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [MW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= mem[raddr_i];
    end
endmodule

// File: rtl/qm_irq.sv
// Interrupt source select, mask and pending logic.
module qm_irq #(
    parameter int NQ = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_we_i,
    input  logic          en_we_i,
    input  logic [NQ-1:0] wdata_i,
    input  logic [NQ-1:0] nonempty_i,
    output logic [NQ-1:0] src_o,
    output logic [NQ-1:0] en_o,
    output logic [NQ-1:0] pend_o,
    output logic          irq_o
);
    logic [NQ-1:0] src, en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            en  <= '0;
        end else begin
            if (src_we_i) src <= wdata_i;
            if (en_we_i)  en  <= wdata_i;
        end
    end

    assign src_o  = src;
    assign en_o   = en;
    assign pend_o = src & en & nonempty_i;
    assign irq_o  = |pend_o;

    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we_i && wdata_i == '0) |=> !irq_o);

endmodule

// File: rtl/hwq_manager.sv
module hwq_manager import qm_pkg::*; #(
    parameter  int N_QUEUES  = 32,
    parameter  int MAX_DEPTH = 64,
    parameter  int DATA_W    = 32,
    localparam int QW        = $clog2(N_QUEUES),
    localparam int ADDR_W    = QW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int PW    = $clog2(MAX_DEPTH);
    localparam int CW    = PW + 1;
    localparam int WORDS = N_QUEUES * MAX_DEPTH;
    localparam int MW    = $clog2(WORDS);

    bus_state_e state_q, state_d;
    region_e    region;
    logic [QW-1:0] sel;
    logic acc, wr, rd;

    logic [N_QUEUES-1:0] put_v, get_v, cfg_v, ovf_clr_v;
    logic [N_QUEUES-1:0] empty_v, full_v, ovf_v, src_v, en_v, pend_v;
    logic [PW-1:0] rd_ptr_a [N_QUEUES];
    logic [PW-1:0] wr_ptr_a [N_QUEUES];
    logic [CW-1:0] len_a    [N_QUEUES];

    logic [DATA_W-1:0] mem_rdata, rd_mux, reg_q;
    logic              pop_empty_q;
    logic              src_we, en_we;

    // ---------------- decode ----------------
    assign region = region_e'(bus_addr[QW+1:QW]);
    assign sel    = bus_addr[QW-1:0];
    assign acc    = bus_req && (state_q == S_IDLE);
    assign wr     = acc && bus_we;
    assign rd     = acc && !bus_we;
    assign src_we = wr && region == RG_GLOBAL && int'(sel) == int'(G_SRC);
    assign en_we  = wr && region == RG_GLOBAL && int'(sel) == int'(G_EN);

    always_comb begin
        put_v     = '0;
        get_v     = '0;
        cfg_v     = '0;
        ovf_clr_v = '0;
        if (acc && region == RG_DATA) begin
            if (bus_we) put_v[sel] = 1'b1;
            else        get_v[sel] = 1'b1;
        end
        if (wr && region == RG_CFG) cfg_v[sel] = 1'b1;
        if (wr && region == RG_GLOBAL && int'(sel) == int'(G_OVF))
            ovf_clr_v = bus_wdata[N_QUEUES-1:0];
    end

    // ---------------- per-queue control ----------------
    for (genvar q = 0; q < N_QUEUES; q++) begin : g_q
        qm_qctrl #(.MAX_DEPTH(MAX_DEPTH), .PW(PW), .CW(CW)) u_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .put_i     (put_v[q]),
            .get_i     (get_v[q]),
            .cfg_we_i  (cfg_v[q]),
            .cfg_len_i (bus_wdata[CW-1:0]),
            .ovf_clr_i (ovf_clr_v[q]),
            .rd_ptr_o  (rd_ptr_a[q]),
            .wr_ptr_o  (wr_ptr_a[q]),
            .len_o     (len_a[q]),
            .empty_o   (empty_v[q]),
            .full_o    (full_v[q]),
            .ovf_o     (ovf_v[q])
        );
    end

    // ---------------- storage ----------------
    qm_store #(.DATA_W(DATA_W), .WORDS(WORDS), .MW(MW)) u_store (
        .clk     (clk),
        .we_i    ((|put_v) && !full_v[sel]),
        .waddr_i (MW'(sel) * MW'(MAX_DEPTH) + MW'(wr_ptr_a[sel])),
        .wdata_i (bus_wdata),
        .re_i    (|get_v),
        .raddr_i (MW'(sel) * MW'(MAX_DEPTH) + MW'(rd_ptr_a[sel])),
        .rdata_o (mem_rdata)
    );

    // ---------------- interrupt ----------------
    qm_irq #(.NQ(N_QUEUES)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_we_i   (src_we),
        .en_we_i    (en_we),
        .wdata_i    (bus_wdata[N_QUEUES-1:0]),
        .nonempty_i (~empty_v),
        .src_o      (src_v),
        .en_o       (en_v),
        .pend_o     (pend_v),
        .irq_o      (irq)
    );

    // ---------------- register read mux ----------------
    always_comb begin
        rd_mux = '0;
        if (region == RG_CFG) begin
            rd_mux = DATA_W'(len_a[sel]);
        end else if (region == RG_GLOBAL) begin
            if      (int'(sel) == int'(G_EMPTY)) rd_mux = DATA_W'(empty_v);
            else if (int'(sel) == int'(G_OVF))   rd_mux = DATA_W'(ovf_v);
            else if (int'(sel) == int'(G_SRC))   rd_mux = DATA_W'(src_v);
            else if (int'(sel) == int'(G_EN))    rd_mux = DATA_W'(en_v);
            else if (int'(sel) == int'(G_PEND))  rd_mux = DATA_W'(pend_v);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            pop_empty_q <= 1'b1;
            reg_q       <= '0;
        end else begin
            state_q <= state_d;
            if (rd) begin
                pop_empty_q <= empty_v[sel];
                reg_q       <= rd_mux;
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (rd) state_d = (region == RG_DATA) ? S_POP_RESP : S_REG_RESP;
            S_POP_RESP: state_d = S_IDLE;
            S_REG_RESP: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            S_IDLE:     bus_ready = 1'b1;
            S_POP_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = pop_empty_q ? '0 : mem_rdata;
            end
            S_REG_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = reg_q;
            end
            default:    bus_ready = 1'b0;
        endcase
    end

    p_read_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (bus_rvalid && !bus_ready));

    p_resp_then_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> bus_ready);

    p_empty_get_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && region == RG_DATA && empty_v[sel]) |=> (bus_rdata == '0));

    p_irq_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (empty_v != '1));

endmodule

// File: tb/tb_hwq_manager.sv
module tb_hwq_manager;
    localparam int  NQ  = 32;
    localparam int  MD  = 64;
    localparam time CLK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_rvalid, irq;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK/2) clk = ~clk;

    hwq_manager dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_mem [NQ][MD];
    int          m_head [NQ];
    int          m_cnt  [NQ];
    int          m_len  [NQ];
    logic [31:0] m_ovf, m_src, m_en;

    function automatic logic [31:0] m_empty();
        logic [31:0] v = '0;
        for (int q = 0; q < NQ; q++) v[q] = (m_cnt[q] == 0);
        return v;
    endfunction

    function automatic logic [31:0] m_pend();
        return m_src & m_en & ~m_empty();
    endfunction

    function automatic void m_reset();
        for (int q = 0; q < NQ; q++) begin
            m_head[q] = 0; m_cnt[q] = 0; m_len[q] = MD;
        end
        m_ovf = '0; m_src = '0; m_en = '0;
    endfunction

    function automatic void m_put(int q, logic [31:0] w);
        if (m_cnt[q] == m_len[q]) m_ovf[q] = 1'b1;
        else begin
            m_mem[q][(m_head[q] + m_cnt[q]) % m_len[q]] = w;
            m_cnt[q]++;
        end
    endfunction

    function automatic logic [31:0] m_get(int q);
        logic [31:0] w;
        if (m_cnt[q] == 0) return 32'd0;
        w = m_mem[q][m_head[q]];
        m_head[q] = (m_head[q] + 1) % m_len[q];
        m_cnt[q]--;
        return w;
    endfunction

    function automatic void m_cfg(int q, logic [31:0] v);
        int l = int'(v[6:0]);
        m_len[q]  = (l == 0 || l > MD) ? MD : l;
        m_head[q] = 0; m_cnt[q] = 0; m_ovf[q] = 1'b0;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------------- bus tasks ----------------
    task automatic bus_wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(logic [6:0] a, output logic [31:0] d, output logic vld, output logic rdy);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata; vld = bus_rvalid; rdy = bus_ready;
    endtask

    task automatic op_put(int q, logic [31:0] w);
        bus_wr(7'(q), w);
        m_put(q, w);
    endtask

    task automatic op_get(int q);
        logic [31:0] d, e; logic v, r;
        bool_empty: begin end
        e = (m_cnt[q] == 0) ? 32'd0 : 32'hx;
        bus_rd(7'(q), d, v, r);
        if (m_cnt[q] == 0) begin
            e = m_get(q);
            chk("R2 empty get returns zero", d, e);
        end else begin
            e = m_get(q);
            chk("R1 get head word", d, e);
        end
        chk("R1 rvalid/ready in response cycle", {30'd0, v, r}, 32'd2);
    endtask

    task automatic op_cfg(int q, logic [31:0] v);
        bus_wr(7'(32 + q), v);
        m_cfg(q, v);
    endtask

    task automatic op_reg(int idx, output logic [31:0] d);
        logic v, r;
        bus_rd(7'(64 + idx), d, v, r);
    endtask

    task automatic chk_status(string tag);
        logic [31:0] d;
        op_reg(0, d); chk({"R6 empty ", tag}, d, m_empty());
        op_reg(1, d); chk({"R4 overflow ", tag}, d, m_ovf);
        op_reg(4, d); chk({"R7 pending ", tag}, d, m_pend());
        chk({"R7 irq ", tag}, {31'd0, irq}, {31'd0, |m_pend()});
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d;
        logic v, r;
        m_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R9 / R6 / R3: reset state
        chk("R9 ready after reset", {31'd0, bus_ready}, 32'd1);
        chk("R9 irq low after reset", {31'd0, irq}, 32'd0);
        op_reg(0, d); chk("R6 R9 all empty", d, 32'hFFFF_FFFF);
        op_reg(1, d); chk("R9 overflow clear", d, 32'd0);
        op_reg(2, d); chk("R9 source select clear", d, 32'd0);
        op_reg(3, d); chk("R9 enable clear", d, 32'd0);
        op_reg(4, d); chk("R9 pending clear", d, 32'd0);
        bus_rd(7'(32 + 5), d, v, r); chk("R3 reset length", d, 32'd64);

        // R2: get from empty queue
        op_get(9);

        // R1 / R4: tags kept, full drop, order kept
        op_cfg(3, 32'd4);
        bus_rd(7'(32 + 3), d, v, r); chk("R3 length readback", d, 32'd4);
        for (int i = 0; i < 5; i++) op_put(3, 32'hA000_0000 + 32'(i * 32) + 32'(i + 1));
        op_reg(1, d); chk("R4 overflow set on full put", d, 32'h0000_0008);
        for (int i = 0; i < 5; i++) op_get(3);

        // R5: write-one-to-clear
        op_cfg(4, 32'd1);
        op_put(4, 32'h11); op_put(4, 32'h22);
        op_reg(1, d); chk("R4 overflow bits 3,4", d, 32'h0000_0018);
        bus_wr(7'(64 + 1), 32'h0000_0010); m_ovf[4] = 1'b0;
        op_reg(1, d); chk("R5 write 1 clears only bit 4", d, 32'h0000_0008);
        bus_wr(7'(64 + 1), 32'h0000_0000);
        op_reg(1, d); chk("R5 write 0 keeps bit 3", d, 32'h0000_0008);
        bus_wr(7'(64 + 1), 32'h0000_0008); m_ovf[3] = 1'b0;
        op_get(4);

        // R7: interrupt select, enable, mask
        bus_wr(7'(64 + 2), 32'h0000_0020); m_src = 32'h20;
        bus_wr(7'(64 + 3), 32'h0000_0020); m_en  = 32'h20;
        chk("R7 irq low while queue 5 empty", {31'd0, irq}, 32'd0);
        op_put(5, 32'hDEAD_BEE0);
        chk("R7 irq on not-empty", {31'd0, irq}, 32'd1);
        op_reg(4, d); chk("R7 pending bit 5", d, 32'h20);
        bus_wr(7'(64 + 3), 32'h0); m_en = '0;
        chk("R7 masked irq low with data", {31'd0, irq}, 32'd0);
        bus_wr(7'(64 + 3), 32'h20); m_en = 32'h20;
        chk("R7 unmask raises irq", {31'd0, irq}, 32'd1);
        op_get(5);
        chk("R7 irq drops when drained", {31'd0, irq}, 32'd0);

        // R3: reallocation empties a queue
        op_put(7, 32'h77); op_put(7, 32'h78);
        op_cfg(7, 32'd0);
        bus_rd(7'(32 + 7), d, v, r); chk("R3 length 0 selects max", d, 32'd64);
        op_get(7);
        op_cfg(8, 32'd100);
        bus_rd(7'(32 + 8), d, v, r); chk("R3 oversize length selects max", d, 32'd64);

        // R8: wrap across length 3
        op_cfg(10, 32'd3);
        op_put(10, 32'h101); op_put(10, 32'h102);
        op_get(10); op_get(10);
        op_put(10, 32'h103); op_put(10, 32'h104); op_put(10, 32'h105);
        op_reg(1, d); chk("R8 no overflow at exact fill after wrap", d, 32'd0);
        op_get(10); op_get(10); op_get(10); op_get(10);

        // R4: maximum depth
        for (int i = 0; i < MD + 1; i++) op_put(31, 32'(i) * 32'h0000_0101);
        op_reg(1, d); chk("R4 overflow at max depth", d, 32'h8000_0000);
        for (int i = 0; i < MD + 1; i++) op_get(31);
        bus_wr(7'(64 + 1), 32'h8000_0000); m_ovf[31] = 1'b0;

        // R10: unmapped region
        op_put(2, 32'h2222);
        bus_wr(7'h60, 32'hFFFF_FFFF);
        bus_wr(7'h7F, 32'hFFFF_FFFF);
        bus_rd(7'h60, d, v, r); chk("R10 unmapped reads zero", d, 32'd0);
        chk_status("after unmapped writes R10");
        op_get(2);

        // random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 4000; n++) begin
            int sel = int'($urandom % 100);
            int q   = ($urandom % 4 == 0) ? int'($urandom % NQ) : int'($urandom % 4);
            if (sel < 40) op_put(q, $urandom);
            else if (sel < 75) op_get(q);
            else if (sel < 80) op_cfg(q, 32'($urandom % 10));
            else if (sel < 85) begin
                logic [31:0] mk = $urandom;
                bus_wr(7'(64 + 1), mk); m_ovf &= ~mk;
            end else if (sel < 88) begin
                logic [31:0] s = $urandom;
                bus_wr(7'(64 + 2), s); m_src = s;
            end else if (sel < 91) begin
                logic [31:0] s = $urandom;
                bus_wr(7'(64 + 3), s); m_en = s;
            end else chk_status("random");
            chk("R7 irq tracks pending", {31'd0, irq}, {31'd0, |m_pend()});
        end
        chk_status("end");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog expired act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule